// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every data beat of an SDRAM read or write burst. A column command pulses the start strobe together with an 8-bit start column. From the next cycle the block presents one column per clock, with a beat-valid flag and a last-beat flag. The column order follows the programmed burst length and burst type.

Two orderings are available. In sequential order the column counts upward and wraps inside an aligned block that is as wide as the burst. In interleaved order the beat index is XORed into the low bits of the start column. A full-page setting (sequential only) walks all 256 columns, wrapping from 255 to 0, until a stop arrives. A stop strobe ends the burst on any cycle. A fresh start strobe on any cycle replaces the burst in progress. When the single-write mode bit is set, write bursts last one beat. A reserved length setting falls back to one beat and raises a sticky configuration error.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, beat_vld_o, last_o and cfg_err_o are 0 and col_o is 0.
- R2: In the cycle after start_i is sampled high, beat_vld_o is 1 and col_o equals the start column that was sampled with it.
- R3: The length code len_code_i is 3'b000 = 1 beat, 3'b001 = 2, 3'b010 = 4, 3'b011 = 8. last_o is high on the final beat only, and beat_vld_o is low in the cycle after the final beat.
- R4: With ilv_i = 0, beat k keeps the start column's bits above log2(BL) and sets the low log2(BL) bits to (start + k) mod BL.
- R5: With ilv_i = 1, beat k keeps the upper bits and sets the low log2(BL) bits to (start XOR k).
- R6: Code 3'b111 with ilv_i = 0 is full page: beat k is (start + k) mod 256, so it wraps from 255 to 0. last_o stays low and the burst continues until it is stopped.
- R7: In the cycle after stop_i is sampled high (with start_i low), beat_vld_o and last_o are 0.
- R8: start_i sampled during a burst restarts the sequence at beat 0 with the new column, length and type.
- R9: With single_wr_i = 1, a burst started with is_write_i = 1 is one beat with last_o high. Read bursts keep their programmed length.
- R10: Codes 3'b100, 3'b101 and 3'b110, and code 3'b111 with ilv_i = 1, give a one-beat burst and set cfg_err_o. cfg_err_o stays high until reset.
- R11: When start_i and stop_i are high in the same cycle, the start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Column command strobe; starts or restarts a burst |
| start_col_i | input | 8 | Start column sampled with start_i |
| is_write_i | input | 1 | The command sampled with start_i is a write |
| stop_i | input | 1 | Burst-stop strobe |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | Burst type: 0 sequential, 1 interleaved |
| single_wr_i | input | 1 | Write bursts are one beat long |
| col_o | output | 8 | Column for the current beat |
| beat_vld_o | output | 1 | A beat is being presented |
| last_o | output | 1 | The current beat is the final one |
| cfg_err_o | output | 1 | Sticky flag for a reserved length setting |

## Verification
A wrong beat index or a corrupted wrap mask shows on col_o at the first beat after the fault, because every column is recomputed from the stored start column each cycle. A length decode fault shows as last_o on the wrong beat, or as beat_vld_o staying high one cycle too long, within at most eight beats. Full-page bursts are followed past the 255-to-0 wrap. A stuck active state shows in the cycle after a stop or after the final beat.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
    typedef enum logic [2:0] {
        LEN_ONE   = 3'b000,
        LEN_TWO   = 3'b001,
        LEN_FOUR  = 3'b010,
        LEN_EIGHT = 3'b011,
        LEN_PAGE  = 3'b111
    } len_code_e;
endpackage

// File: rtl/colgen_len_dec.sv
module colgen_len_dec #(
    parameter int COL_W = 8
) (
    input  logic [2:0]       code_i,
    input  logic             ilv_i,
    input  logic             is_write_i,
    input  logic             single_wr_i,
    output logic [COL_W-1:0] mask_o,
    output logic             page_o,
    output logic             bad_o
);
    import colgen_pkg::*;

    logic [COL_W-1:0] mask_raw;
    logic             page_raw;

    always_comb begin
        mask_raw = '0;
        page_raw = 1'b0;
        bad_o    = 1'b0;
        case (code_i)
            LEN_ONE:   mask_raw = COL_W'(0);
            LEN_TWO:   mask_raw = COL_W'(1);
            LEN_FOUR:  mask_raw = COL_W'(3);
            LEN_EIGHT: mask_raw = COL_W'(7);
            LEN_PAGE: begin
                if (ilv_i) begin
                    bad_o = 1'b1;
                end else begin
                    mask_raw = '1;
                    page_raw = 1'b1;
                end
            end
            default:   bad_o = 1'b1;
        endcase
        if (is_write_i && single_wr_i) begin
            mask_o = '0;
            page_o = 1'b0;
        end else begin
            mask_o = mask_raw;
            page_o = page_raw;
        end
    end
endmodule

// File: rtl/colgen_col_calc.sv
module colgen_col_calc #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] idx_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] seq_low;
    logic [COL_W-1:0] ilv_low;

    always_comb begin
        seq_low = (base_i + idx_i) & mask_i;
        ilv_low = (base_i ^ idx_i) & mask_i;
        col_o   = (base_i & ~mask_i) | (ilv_i ? ilv_low : seq_low);
    end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             is_write_i,
    input  logic             stop_i,
    input  logic [2:0]       len_code_i,
    input  logic             ilv_i,
    input  logic             single_wr_i,
    output logic [COL_W-1:0] col_o,
    output logic             beat_vld_o,
    output logic             last_o,
    output logic             cfg_err_o
);
    typedef struct packed {
        logic             active;
        logic             last;
        logic             page;
        logic             ilv;
        logic             err;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] idx;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] col;
    } state_t;

    state_t st_d, st_q;

    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic             dec_bad;
    logic [COL_W-1:0] idx_nxt;
    logic [COL_W-1:0] col_nxt;

    colgen_len_dec #(.COL_W(COL_W)) u_dec (
        .code_i      (len_code_i),
        .ilv_i       (ilv_i),
        .is_write_i  (is_write_i),
        .single_wr_i (single_wr_i),
        .mask_o      (dec_mask),
        .page_o      (dec_page),
        .bad_o       (dec_bad)
    );

    assign idx_nxt = st_q.idx + COL_W'(1);

    colgen_col_calc #(.COL_W(COL_W)) u_calc (
        .base_i (st_q.base),
        .idx_i  (idx_nxt),
        .mask_i (st_q.mask),
        .ilv_i  (st_q.ilv),
        .col_o  (col_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.base   = start_col_i;
            st_d.idx    = '0;
            st_d.mask   = dec_mask;
            st_d.page   = dec_page;
            st_d.ilv    = ilv_i;
            st_d.col    = start_col_i;
            st_d.last   = (dec_mask == '0) && !dec_page;
            st_d.err    = st_q.err | dec_bad;
        end else if (stop_i) begin
            st_d.active = 1'b0;
            st_d.last   = 1'b0;
        end else if (st_q.active) begin
            if (st_q.last) begin
                st_d.active = 1'b0;
                st_d.last   = 1'b0;
            end else begin
                st_d.idx  = idx_nxt;
                st_d.col  = col_nxt;
                st_d.last = !st_q.page && (idx_nxt == st_q.mask);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_o      = st_q.col;
    assign beat_vld_o = st_q.active;
    assign last_o     = st_q.last;
    assign cfg_err_o  = st_q.err;
endmodule

// File: rtl/colgen_chk.sv
module colgen_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             is_write_i,
    input logic             stop_i,
    input logic             single_wr_i,
    input logic [COL_W-1:0] col_o,
    input logic             beat_vld_o,
    input logic             last_o,
    input logic             cfg_err_o
);
    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> beat_vld_o && col_o == $past(start_col_i)); // R2

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        last_o && !start_i |=> !beat_vld_o); // R3

    AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> beat_vld_o); // R3

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i && !start_i |=> !beat_vld_o && !last_o); // R7

    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && is_write_i && single_wr_i |=> last_o); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |=> cfg_err_o); // R10

    AST_START_OVER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && stop_i |=> beat_vld_o); // R11
endmodule

bind sdram_burst_colgen colgen_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .is_write_i  (is_write_i),
    .stop_i      (stop_i),
    .single_wr_i (single_wr_i),
    .col_o       (col_o),
    .beat_vld_o  (beat_vld_o),
    .last_o      (last_o),
    .cfg_err_o   (cfg_err_o)
);

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic       is_write_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [2:0] len_code_i = '0;
    logic       ilv_i = 1'b0;
    logic       single_wr_i = 1'b0;
    logic [7:0] col_o;
    logic       beat_vld_o;
    logic       last_o;
    logic       cfg_err_o;

    int total = 0;
    int bad = 0;
    bit exp_err = 1'b0;

    always #2 clk = ~clk;

    sdram_burst_colgen dut (.*);

    // vector: {code[2:0], ilv, write, single_wr, 2'b00, start_col[7:0]}
    localparam int NV = 12;
    localparam logic [15:0] VEC [NV] = '{
        {3'b000, 1'b0, 1'b0, 1'b0, 2'b00, 8'h37},
        {3'b001, 1'b0, 1'b0, 1'b0, 2'b00, 8'h37},
        {3'b010, 1'b0, 1'b0, 1'b0, 2'b00, 8'h37},
        {3'b011, 1'b0, 1'b0, 1'b0, 2'b00, 8'h3D},
        {3'b011, 1'b1, 1'b0, 1'b0, 2'b00, 8'h3D},
        {3'b010, 1'b1, 1'b0, 1'b0, 2'b00, 8'h82},
        {3'b001, 1'b1, 1'b0, 1'b0, 2'b00, 8'hFF},
        {3'b011, 1'b0, 1'b1, 1'b1, 2'b00, 8'hA5},
        {3'b011, 1'b0, 1'b0, 1'b1, 2'b00, 8'hA5},
        {3'b011, 1'b1, 1'b1, 1'b0, 2'b00, 8'h5E},
        {3'b100, 1'b0, 1'b0, 1'b0, 2'b00, 8'h12},
        {3'b111, 1'b1, 1'b0, 1'b0, 2'b00, 8'h34}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic bit is_bad_code(input logic [2:0] code, input logic ilv);
        return (code inside {3'b100, 3'b101, 3'b110}) || (code == 3'b111 && ilv);
    endfunction

    function automatic int beats_of(input logic [2:0] code, input logic ilv,
                                    input logic wr, input logic sw);
        if (is_bad_code(code, ilv)) return 1;
        if (wr && sw) return 1;
        if (code == 3'b111) return 256;
        return 1 << code;
    endfunction

    function automatic int exp_col(input int base, input int k, input int bl, input bit ilv);
        int blk, off;
        blk = (base / bl) * bl;
        off = base % bl;
        if (ilv) off = off ^ (k % bl);
        else     off = (off + k) % bl;
        return blk + off;
    endfunction

    task automatic launch(input logic [2:0] code, input logic ilv, input logic wr,
                          input logic sw, input logic [7:0] col);
        len_code_i  = code;
        ilv_i       = ilv;
        is_write_i  = wr;
        single_wr_i = sw;
        start_col_i = col;
        start_i     = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (is_bad_code(code, ilv)) exp_err = 1'b1;
    endtask

    task automatic follow(input int n, input int base, input int bl, input bit ilv, input string req);
        for (int k = 0; k < n; k++) begin
            int ec;
            ec = exp_col(base, k, bl, ilv);
            chk(beat_vld_o == 1'b1, req, beat_vld_o, 1);
            chk(col_o == 8'(ec), req, col_o, ec);
            chk(last_o == (k == n - 1), req, last_o, (k == n - 1));
            chk(cfg_err_o == exp_err, "R10", cfg_err_o, exp_err);
            @(negedge clk);
        end
        chk(beat_vld_o == 1'b0, "R3", beat_vld_o, 0);
        chk(last_o == 1'b0, "R3", last_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(beat_vld_o == 0 && last_o == 0 && cfg_err_o == 0 && col_o == 0,
            "R1", {beat_vld_o, last_o, cfg_err_o, col_o}, 0);

        // table walk: R2 R3 R4 R5 R9 R10
        for (int v = 0; v < NV; v++) begin
            logic [2:0] c;
            logic il, w, s;
            logic [7:0] sc;
            int n;
            {c, il, w, s} = VEC[v][15:10];
            sc = VEC[v][7:0];
            n = beats_of(c, il, w, s);
            launch(c, il, w, s, sc);
            follow(n, sc, n, il, il ? "R5" : (w && s ? "R9" : "R4"));
            @(negedge clk);
        end

        // full page wrap and stop: R6 R7
        launch(3'b111, 1'b0, 1'b0, 1'b0, 8'hFA);
        for (int k = 0; k < 260; k++) begin
            chk(beat_vld_o == 1'b1, "R6", beat_vld_o, 1);
            chk(col_o == 8'((250 + k) % 256), "R6", col_o, (250 + k) % 256);
            chk(last_o == 1'b0, "R6", last_o, 0);
            if (k == 259) stop_i = 1'b1;
            @(negedge clk);
        end
        stop_i = 1'b0;
        chk(beat_vld_o == 1'b0 && last_o == 1'b0, "R7", beat_vld_o, 0);
        @(negedge clk);
        chk(beat_vld_o == 1'b0, "R7", beat_vld_o, 0);

        // restart mid-burst: R8
        launch(3'b011, 1'b0, 1'b0, 1'b0, 8'h10);
        for (int k = 0; k < 3; k++) begin
            chk(col_o == 8'(8'h10 + k), "R8", col_o, 8'h10 + k);
            if (k < 2) @(negedge clk);
        end
        launch(3'b010, 1'b1, 1'b0, 1'b0, 8'h45);
        follow(4, 8'h45, 4, 1'b1, "R8");

        // start and stop together: R11
        stop_i = 1'b1;
        launch(3'b001, 1'b0, 1'b0, 1'b0, 8'h20);
        stop_i = 1'b0;
        chk(beat_vld_o == 1'b1, "R11", beat_vld_o, 1);
        chk(col_o == 8'h20, "R11", col_o, 8'h20);
        @(negedge clk);
        chk(col_o == 8'h21 && last_o == 1'b1, "R11", col_o, 8'h21);
        @(negedge clk);

        // error clears only with reset: R10
        chk(cfg_err_o == 1'b1, "R10", cfg_err_o, 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_err_o == 1'b0, "R10", cfg_err_o, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule